// File: doc/BRIEF.md
# Edge-Latched Address Static Memory

This block is a 2048-word by 8-bit static memory. Its address is not applied continuously: it is captured when the active-low chip enable falls. The three active-low strobes (chip enable, output enable, write enable) come from another timing domain. Each one passes through a synchronizer clocked by a fast system clock, and all sequencing is counted in cycles of that clock.

In a read cycle the block asserts a drive flag one cycle after the cycle opens, then presents valid data one cycle later. The drive flag stands in for the enable of three-state pins. A write is committed on whichever ends the cycle first: write enable rising or chip enable rising. Write enable may stay low across several chip-enable cycles, and each cycle then commits one word at its own latched address.

Minimum chip-enable high and low times are parameters in clock cycles. A cycle that breaks them is rejected, as is a write that ends with no address latched. Both rejections raise a one-cycle error pulse.

Top module: `edge_latch_sram`

## Requirements
- R1: While reset is asserted and right after it is released, `drive_o`, `dvalid_o` and `err_o` are 0 and `rdata_o` is 0. No cycle is open and no address is latched.
- R2: All three strobes are active low. The address is captured at the third rising clock edge after `ce_n_i` falls. Changing `addr_i` after that edge does not affect the cycle in progress.
- R3: In a read cycle (`we_n_i` high), `drive_o` is 0 after the third edge following the `ce_n_i` fall. It is 1 after the fourth edge with `dvalid_o` 0, and after the fifth edge `dvalid_o` is 1 with the stored word on `rdata_o`. Once write enable has been seen low in a cycle, `drive_o` stays 0 for the rest of that cycle.
- R4: When `ce_n_i` rises, `drive_o` is still 1 after the second edge and is 0 after the third edge. The block then returns to the deselected state.
- R5: While `oe_n_i` is high, `drive_o` is 0. `drive_o` follows `oe_n_i` with a latency of two edges in both directions. `rdata_o` is 0 whenever `dvalid_o` is 0.
- R6: A write commits the value on `wdata_i` at the third edge after the first rising of `we_n_i` or `ce_n_i` that ends the cycle. Later data changes do not affect the stored word.
- R7: With `we_n_i` held low across several chip-enable cycles, each `ce_n_i` rise commits one word to that cycle's latched address. The final rise of `we_n_i` raises no error.
- R8: A `we_n_i` pulse while no cycle is open writes nothing and produces exactly one single-cycle `err_o` pulse.
- R9: A `ce_n_i` fall seen fewer than `MIN_CE_HIGH` cycles after the previous cycle closed is ignored: no drive and no write.
- R10: If `ce_n_i` rises fewer than `MIN_CE_LOW` cycles into a cycle while a write is pending, the write is dropped and exactly one `err_o` pulse is raised.
- R11: Every one of the 2048 addresses, including 0 and 2047, stores and returns its own 8-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | 11 | Word address, latched at the start of a cycle |
| wdata_i | input | 8 | Write data, sampled when the write ends |
| rdata_o | output | 8 | Read data; 0 while not valid |
| drive_o | output | 1 | Output drivers enabled |
| dvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | One-cycle pulse on a rejected write |

## Verification
A wrong latched address or a missed write-mode flag appears as wrong `rdata_o` in the fifth cycle of the next read of that word, or as `drive_o` rising during a write. A stuck cycle-open state keeps `drive_o` high past the third edge after chip enable rises, so it is seen within three cycles. A wrong burst or pending-write flag shows up at the ports as a missing or extra `err_o` pulse, or as a changed word when the location is read back.

// File: rtl/els_pkg.sv
package els_pkg;

    // bit positions of the strobes inside the synchronizer vector
    localparam int SIG_CE = 0;
    localparam int SIG_OE = 1;
    localparam int SIG_WE = 2;
    localparam int SIG_N  = 3;

    // progress of an open cycle
    typedef enum logic [1:0] {
        PH_OPEN  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_VALID = 2'd2
    } phase_e;

endpackage

// File: rtl/els_sync.sv
module els_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/els_ctrl.sv
module els_ctrl
    import els_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 8,
    parameter int MIN_CE_HIGH = 8,
    parameter int MIN_CE_LOW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          drive_o,
    output logic          dvalid_o,
    output logic          err_o
);

    localparam int HW = $clog2(MIN_CE_HIGH + 1);
    localparam int LW = $clog2(MIN_CE_LOW + 1);
    localparam logic [HW-1:0] HI_SAT = HW'(MIN_CE_HIGH);
    localparam logic [LW-1:0] LO_SAT = LW'(MIN_CE_LOW);

    typedef struct packed {
        logic          act;    // cycle open, address valid
        phase_e        ph;
        logic          wmode;  // write enable seen low in this cycle
        logic          wpend;  // write waiting for its ending edge
        logic          burst;  // write enable still low after a CE-ended write
        logic [AW-1:0] addr;
        logic [HW-1:0] hi_cnt;
        logic [LW-1:0] lo_cnt;
        logic          err;
        logic          ce_p;
        logic          we_p;
    } st_t;

    st_t  st_q, st_d;
    logic commit;
    logic ce_fall, ce_rise, we_rise;

    assign ce_fall = st_q.ce_p & ~ce_s;
    assign ce_rise = ~st_q.ce_p & ce_s;
    assign we_rise = ~st_q.we_p & we_s;

    always_comb begin
        st_d      = st_q;
        commit    = 1'b0;
        st_d.err  = 1'b0;
        st_d.ce_p = ce_s;
        st_d.we_p = we_s;
        if (!st_q.act) begin
            if (st_q.hi_cnt != HI_SAT) st_d.hi_cnt = st_q.hi_cnt + 1'b1;
            if (we_rise) begin
                if (st_q.burst) st_d.burst = 1'b0;
                else            st_d.err   = 1'b1;
            end
            if (ce_fall && (st_q.hi_cnt >= HI_SAT)) begin
                st_d.act    = 1'b1;
                st_d.ph     = PH_OPEN;
                st_d.addr   = addr_i;
                st_d.lo_cnt = '0;
                st_d.wmode  = ~we_s;
                st_d.wpend  = ~we_s;
            end
        end else begin
            if (st_q.lo_cnt != LO_SAT) st_d.lo_cnt = st_q.lo_cnt + 1'b1;
            if (st_q.ph != PH_VALID) st_d.ph = phase_e'(st_q.ph + 2'd1);
            if (!we_s) begin
                st_d.wmode = 1'b1;
                st_d.wpend = 1'b1;
            end
            if (we_rise && st_q.wpend) begin
                commit      = 1'b1;
                st_d.wpend  = 1'b0;
                st_d.burst  = 1'b0;
            end else if (ce_rise && st_q.wpend) begin
                if (st_q.lo_cnt >= LO_SAT) commit   = 1'b1;
                else                       st_d.err = 1'b1;
                st_d.burst = ~we_s;
            end
            if (ce_rise) begin
                st_d.act    = 1'b0;
                st_d.wpend  = 1'b0;
                st_d.wmode  = 1'b0;
                st_d.hi_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: 1'b0, ph: PH_OPEN, wmode: 1'b0, wpend: 1'b0,
                      burst: 1'b0, addr: '0, hi_cnt: HI_SAT, lo_cnt: '0,
                      err: 1'b0, ce_p: 1'b1, we_p: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = commit;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = wdata_i;
    assign drive_o   = st_q.act & (st_q.ph != PH_OPEN) & ~st_q.wmode & ~oe_s;
    assign dvalid_o  = drive_o & (st_q.ph == PH_VALID);
    assign err_o     = st_q.err;

endmodule

// File: rtl/els_mem.sv
module els_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];
    logic [DW-1:0] rd_q;

    // storage array carries no reset
    always_ff @(posedge clk) begin
        if (we) cell_q[addr] <= wdata;
        rd_q <= cell_q[addr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/edge_latch_sram.sv
module edge_latch_sram
    import els_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CE_HIGH = 8,
    parameter int MIN_CE_LOW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o,
    output logic              dvalid_o,
    output logic              err_o
);

    logic [SIG_N-1:0]  raw, syn;
    logic              ce_s, oe_s, we_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    assign raw[SIG_CE] = ce_n_i;
    assign raw[SIG_OE] = oe_n_i;
    assign raw[SIG_WE] = we_n_i;

    els_sync #(.WIDTH(SIG_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign ce_s = syn[SIG_CE];
    assign oe_s = syn[SIG_OE];
    assign we_s = syn[SIG_WE];

    els_ctrl #(
        .AW(ADDR_W), .DW(DATA_W),
        .MIN_CE_HIGH(MIN_CE_HIGH), .MIN_CE_LOW(MIN_CE_LOW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
        .addr_i(addr_i), .wdata_i(wdata_i),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .drive_o(drive_o), .dvalid_o(dvalid_o), .err_o(err_o)
    );

    els_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assign rdata_o = dvalid_o ? mem_rdata : '0;

endmodule

// File: rtl/els_chk.sv
module els_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_s,
    input logic          oe_s,
    input logic          we_s,
    input logic          drive_o,
    input logic          dvalid_o,
    input logic          err_o,
    input logic          mem_we,
    input logic [DW-1:0] rdata_o
);

    AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_s |-> !drive_o); // R5

    AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_o |-> drive_o); // R3

    AST_DATA_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid_o |-> (rdata_o == '0)); // R5

    AST_CE_HIGH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && $past(ce_s)) |-> !drive_o); // R4

    AST_WE_LOW_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_s && !$past(we_s)) |-> !drive_o); // R3

    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((we_s && !$past(we_s)) || (ce_s && !$past(ce_s)))); // R6

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !$past(mem_we)); // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R10

endmodule

bind edge_latch_sram els_chk #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .drive_o(drive_o), .dvalid_o(dvalid_o), .err_o(err_o),
    .mem_we(mem_we), .rdata_o(rdata_o)
);

// File: tb/tb_edge_latch_sram.sv
`timescale 1ns/1ps
module tb_edge_latch_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        drive, dvalid, err;

    int checks = 0, failures = 0, err_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_latch_sram dut (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .drive_o(drive), .dvalid_o(dvalid), .err_o(err)
    );

    always @(posedge clk) if (rst_n && err === 1'b1) err_cnt++;

    // {address, data}
    localparam logic [18:0] VEC [8] = '{
        {11'h000, 8'hA5}, {11'h7FF, 8'h3C}, {11'h001, 8'h5A}, {11'h400, 8'hFF},
        {11'h2AA, 8'h00}, {11'h155, 8'h81}, {11'h123, 8'h7E}, {11'h3FF, 8'h42}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [10:0] a, input logic [7:0] d);
        addr = a; wdata = d; oe_n = 1'b0; ce_n = 1'b0;
        tick(4);
        addr = ~a; we_n = 1'b0;
        tick(6);
        chk("R3 no drive in write", {31'b0, drive}, 0);
        we_n = 1'b1;
        tick(4);
        wdata = ~d;
        tick(2);
        chk("R3 drive stays off after write", {31'b0, drive}, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(14);
    endtask

    task automatic do_read(input logic [10:0] a, input logic [7:0] exp, input string tag);
        addr = a; oe_n = 1'b0; ce_n = 1'b0;
        tick(3);
        chk("R3 drive off at edge 3", {31'b0, drive}, 0);
        addr = ~a;
        tick(1);
        chk("R3 drive on at edge 4", {30'b0, drive, dvalid}, 2);
        tick(1);
        chk("R3 valid at edge 5", {31'b0, dvalid}, 1);
        chk(tag, {24'b0, rdata}, {24'b0, exp});
        tick(3);
        ce_n = 1'b1;
        tick(2);
        chk("R4 drive held 2 edges", {31'b0, drive}, 1);
        tick(1);
        chk("R4 drive off 3 edges", {23'b0, drive, rdata}, 0);
        oe_n = 1'b1;
        tick(12);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int e0;
        tick(5);
        chk("R1 reset outputs", {21'b0, drive, dvalid, err, rdata}, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 after release", {21'b0, drive, dvalid, err, rdata}, 0);

        // table walk: R11 full range, R2 address change, R6 first-rise data
        for (int i = 0; i < 8; i++) do_write(VEC[i][18:8], VEC[i][7:0]);
        for (int i = 0; i < 8; i++) do_read(VEC[i][18:8], VEC[i][7:0], "R11 R2 R6 readback");

        // R5 output enable gating
        addr = 11'h000; oe_n = 1'b1; ce_n = 1'b0;
        tick(6);
        chk("R5 OE high no drive", {31'b0, drive}, 0);
        oe_n = 1'b0;
        tick(1);
        chk("R5 OE latency 1", {31'b0, drive}, 0);
        tick(1);
        chk("R5 OE on", {22'b0, drive, dvalid, rdata}, {22'b0, 2'b11, 8'hA5});
        oe_n = 1'b1;
        tick(1);
        chk("R5 OE off latency 1", {31'b0, drive}, 1);
        tick(1);
        chk("R5 OE off", {23'b0, drive, rdata}, 0);
        ce_n = 1'b1;
        tick(14);

        // R7 burst of writes with WE held low
        e0 = err_cnt;
        we_n = 1'b0;
        tick(2);
        for (int i = 0; i < 3; i++) begin
            addr = 11'h050 + 11'(i); wdata = 8'h90 + 8'(i); ce_n = 1'b0;
            tick(4);
            addr = 11'h7AA;
            tick(10);
            ce_n = 1'b1;
            tick(4);
            wdata = 8'hEE;
            tick(12);
        end
        we_n = 1'b1;
        tick(6);
        chk("R7 burst no error", err_cnt, e0);
        for (int i = 0; i < 3; i++) do_read(11'h050 + 11'(i), 8'h90 + 8'(i), "R7 burst word");

        // R8 write enable pulse while deselected
        e0 = err_cnt;
        wdata = 8'h11;
        we_n = 1'b0;
        tick(4);
        we_n = 1'b1;
        tick(6);
        chk("R8 one error pulse", err_cnt, e0 + 1);
        do_read(11'h052, 8'h92, "R8 no write done");

        // R10 chip enable low too short with a pending write
        do_write(11'h060, 8'h11);
        e0 = err_cnt;
        we_n = 1'b0;
        tick(2);
        addr = 11'h060; wdata = 8'hC3; ce_n = 1'b0;
        tick(3);
        ce_n = 1'b1;
        tick(4);
        we_n = 1'b1;
        tick(12);
        chk("R10 one error pulse", err_cnt, e0 + 1);
        do_read(11'h060, 8'h11, "R10 write dropped");

        // R9 chip enable high too short: next fall ignored
        addr = 11'h060; oe_n = 1'b0; ce_n = 1'b0;
        tick(10);
        ce_n = 1'b1;
        tick(3);
        ce_n = 1'b0;
        tick(10);
        chk("R9 short high ignored", {31'b0, drive}, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(14);
        do_read(11'h060, 8'h11, "R9 next cycle works");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule